// File: doc/BRIEF.md
# Externally Clocked Conversion Host Controller

This block is the host side of a serial link to an analog-to-digital converter that runs in its externally clocked mode. In that mode the converter has no conversion clock of its own: the serial clock the host sends both shifts the data and paces the conversion. Each conversion is one frame. The host lowers chip-select, sends an 8-bit command byte that selects the channel, and then sends exactly 16 more serial clocks. During those clocks the converter shifts the result back. The mode has no scanning, no averaging and no result buffering, so one command always yields one sample.

A client starts a conversion by offering a channel number on a valid/ready request port. The 10-bit sample comes back on a valid/ready result port, together with the channel it belongs to. The serial clock half-period is a parameter counted in system clocks. A build option lets the controller raise chip-select briefly between the eighth and ninth serial clocks. The converter accepts that pulse only if it is shorter than 100 µs, so the pulse width is checked against that limit when the design is elaborated. When the client has the next request ready, conversions run back to back with no idle time between frames.

Top module: `conv_host_ctrl`

## Requirements
- R1: During reset and in idle, `spi_csn` is 1, `spi_sclk` is 0, `spi_mosi` is 0, `res_valid` is 0, and `req_ready` is 1 once reset is released.
- R2: A conversion frame holds exactly CMD_BITS + CONV_CLKS (8 + 16) rising edges of `spi_sclk`. Each level of the serial clock lasts SCLK_DIV system clocks, so consecutive rising edges within one stretch of chip-select low are 2·SCLK_DIV system clocks apart.
- R3: The command byte is `{1'b1, channel[3:0], 3'b000}` and goes out MSB first on `spi_mosi`. The line changes only while `spi_sclk` is low and is stable at every rising edge.
- R4: `spi_miso` is sampled on falling edges of `spi_sclk`. The result is the ten bits sampled on clocks 9 to 18, with the first bit as the MSB. Whatever the converter sends on clocks 19 to 24 has no effect on the result.
- R5: `res_valid` rises in the system cycle after the falling edge of clock 18. `res_chan` holds the requested channel. `res_data` and `res_valid` hold steady until `res_ready` is 1.
- R6: With GAP_EN set, `spi_csn` goes high for exactly GAP_CYC system clocks between the falling edge of clock 8 and the rising edge of clock 9, with `spi_sclk` low throughout. Elaboration fails if GAP_CYC system clocks reach 100 µs at CLK_HZ.
- R7: A request that is waiting when clock 24 falls is accepted in that same cycle. `spi_csn` stays low and the next frame's first rising edge follows SCLK_DIV system clocks after that falling edge.
- R8: `req_ready` is 0 while a result is waiting on the result port and during a frame, except in the cycle in which clock 24 falls. A request held while it is blocked starts no frame.
- R9: Apart from the pulse of R6, `spi_csn` stays low from the start of a frame to its 24th falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_chan | input | CH_BITS | Channel to convert |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Client takes the result |
| res_data | output | RES_BITS | Converted sample |
| res_chan | output | CH_BITS | Channel of the sample |
| spi_csn | output | 1 | Chip-select to the converter, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Result data from the converter |

## Verification
The bench builds the controller with SCLK_DIV = 2, a 4-bit channel, GAP_EN = 1 and GAP_CYC = 5 at a 100 MHz nominal clock. With these values every one of the 16 channels can be swept in one back-to-back run of a few thousand cycles, and the mid-frame chip-select pulse appears in every frame. A converter model in the bench decodes each command byte and returns a sample computed from the channel and the frame index. It drives ones on the six discarded clocks. Isolated requests and a stalled result port are also covered.

// File: rtl/conv_host_pkg.sv
package conv_host_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } conv_state_e;
endpackage

// File: rtl/conv_host_div.sv
// Half-period timer for the serial clock: pulses tick every DIV cycles while run is high.
module conv_host_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/conv_host_rx.sv
// Captures result bits and holds the finished sample on the result port.
module conv_host_rx #(
  parameter int RES_BITS = 10,
  parameter int CH_BITS  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_en,
  input  logic                cap_last,
  input  logic                miso,
  input  logic [CH_BITS-1:0]  chan_in,
  input  logic                res_ready,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data,
  output logic [CH_BITS-1:0]  res_chan
);
  logic [RES_BITS-2:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr        <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else begin
      if (cap_en) sr <= {sr[RES_BITS-3:0], miso};
      if (cap_last) begin
        res_data  <= {sr, miso};
        res_chan  <= chan_in;
        res_valid <= 1'b1;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/conv_host_ctrl.sv
module conv_host_ctrl
  import conv_host_pkg::*;
#(
  parameter int SCLK_DIV   = 2,
  parameter int CMD_BITS   = 8,
  parameter int CONV_CLKS  = 16,
  parameter int RES_BITS   = 10,
  parameter int CH_BITS    = 4,
  parameter int GAP_EN     = 0,
  parameter int GAP_CYC    = 4,
  parameter int CLK_HZ     = 100_000_000,
  parameter int GAP_MAX_US = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CH_BITS-1:0]  req_chan,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [RES_BITS-1:0] res_data,
  output logic [CH_BITS-1:0]  res_chan,
  output logic                spi_csn,
  output logic                spi_sclk,
  output logic                spi_mosi,
  input  logic                spi_miso
);
  localparam int TOT  = CMD_BITS + CONV_CLKS;
  localparam int PH   = 2 * TOT;
  localparam int PHW  = $clog2(PH);
  localparam int PADW = CMD_BITS - 1 - CH_BITS;
  localparam int GW   = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  // Elaboration guard on the mid-frame chip-select pulse width.
  if (GAP_EN != 0 && (GAP_CYC < 1 ||
      longint'(GAP_CYC) * 64'd1000000 >= longint'(GAP_MAX_US) * longint'(CLK_HZ))) begin : g_bad_gap
    $error("chip-select pulse of GAP_CYC clocks is not below the converter limit");
  end

  conv_state_e        state;
  logic [PHW-1:0]     ph;
  logic [PHW-1:0]     clk_idx;
  logic [CMD_BITS-2:0] cmd_sr;
  logic [CH_BITS-1:0] cur_chan;
  logic               tick, gap_done;
  logic               fall_tick, rise_tick, end_tick, mid_tick;
  logic               cap_en, cap_last, accept;
  logic [CMD_BITS-1:0] cmd_w;

  conv_host_div #(.DIV(SCLK_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_SHIFT),
    .tick (tick)
  );

  assign clk_idx   = ph >> 1;
  assign rise_tick = tick && !ph[0];
  assign fall_tick = tick && ph[0];
  assign end_tick  = fall_tick && (ph == PHW'(PH - 1));
  assign mid_tick  = fall_tick && (clk_idx == PHW'(CMD_BITS - 1));
  assign cap_en    = fall_tick && (clk_idx >= PHW'(CMD_BITS)) &&
                     (clk_idx < PHW'(CMD_BITS + RES_BITS));
  assign cap_last  = fall_tick && (clk_idx == PHW'(CMD_BITS + RES_BITS - 1));

  assign req_ready = !res_valid && (state == ST_IDLE || end_tick);
  assign accept    = req_valid && req_ready;
  assign cmd_w     = {1'b1, req_chan, {PADW{1'b0}}};

  if (GAP_EN != 0) begin : g_gap
    logic [GW-1:0] gap_cnt;
    always_ff @(posedge clk) begin
      if (rst || state != ST_GAP) gap_cnt <= '0;
      else                        gap_cnt <= gap_cnt + 1'b1;
    end
    assign gap_done = (gap_cnt == GW'(GAP_CYC - 1));
  end else begin : g_nogap
    assign gap_done = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      spi_csn  <= 1'b1;
      spi_sclk <= 1'b0;
      spi_mosi <= 1'b0;
      cmd_sr   <= '0;
      ph       <= '0;
      cur_chan <= '0;
    end else if (accept) begin
      state               <= ST_SHIFT;
      spi_csn             <= 1'b0;
      spi_sclk            <= 1'b0;
      {spi_mosi, cmd_sr}  <= cmd_w;
      ph                  <= '0;
      cur_chan            <= req_chan;
    end else if (state == ST_SHIFT && tick) begin
      ph <= (ph == PHW'(PH - 1)) ? '0 : ph + 1'b1;
      if (rise_tick) begin
        spi_sclk <= 1'b1;
      end else begin
        spi_sclk           <= 1'b0;
        {spi_mosi, cmd_sr} <= {cmd_sr, 1'b0};
        if (end_tick) begin
          state   <= ST_IDLE;
          spi_csn <= 1'b1;
        end else if (mid_tick && GAP_EN != 0) begin
          state   <= ST_GAP;
          spi_csn <= 1'b1;
        end
      end
    end else if (state == ST_GAP && gap_done) begin
      state   <= ST_SHIFT;
      spi_csn <= 1'b0;
    end
  end

  conv_host_rx #(.RES_BITS(RES_BITS), .CH_BITS(CH_BITS)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .cap_last  (cap_last),
    .miso      (spi_miso),
    .chan_in   (cur_chan),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_chan  (res_chan)
  );
endmodule

// File: rtl/conv_host_ctrl_chk.sv
module conv_host_ctrl_chk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                req_ready,
  input logic                res_valid,
  input logic                res_ready,
  input logic [RES_BITS-1:0] res_data,
  input logic                spi_csn,
  input logic                spi_sclk,
  input logic                spi_mosi
);
  // R1: the cycle after a reset edge shows idle serial lines and no result
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (spi_csn && !spi_sclk && !spi_mosi && !res_valid));

  // R3: command data never moves at a rising serial-clock edge
  a_r3_mosi_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  // R5: an unconsumed result stays put
  a_r5_result_hold: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R6: the serial clock is low whenever chip-select is high
  a_r6_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
    spi_csn |-> !spi_sclk);

  // R8: no request is taken while a result waits
  a_r8_block_when_full: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !req_ready);
endmodule

bind conv_host_ctrl conv_host_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .spi_csn   (spi_csn),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi)
);

// File: tb/conv_host_ctrl_tb_top.sv
module conv_host_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int GAPC  = 5;
  localparam int TOT   = 24;
  localparam int NSWEEP = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_chan = '0;
  logic       res_valid;
  logic       res_ready = 1'b1;
  logic [9:0] res_data;
  logic [3:0] res_chan;
  logic       spi_csn, spi_sclk, spi_mosi;
  logic       spi_miso = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int exp_ch[64];
  int n_sent = 0;
  int n_rcv  = 0;
  int b2b_checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_host_ctrl #(
    .SCLK_DIV(DIV), .CMD_BITS(8), .CONV_CLKS(16), .RES_BITS(10), .CH_BITS(4),
    .GAP_EN(1), .GAP_CYC(GAPC), .CLK_HZ(100_000_000), .GAP_MAX_US(100)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_chan(res_chan), .spi_csn(spi_csn),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sample_of(input int ch, input int k);
    return (ch * 71 + k * 29 + 5) & 10'h3FF;
  endfunction

  // ---------------- converter model ----------------
  int       s_cnt = 0;
  int       s_frame = 0;
  logic [7:0] s_cmd = '0;
  logic [9:0] s_val = '0;
  time      t_rise = 0;
  time      t_end = 0;
  time      t_csr = 0;
  bit       end_seen = 1'b0;
  bit       csn_rose = 1'b0;

  always @(posedge spi_sclk) begin
    s_cnt = s_cnt + 1;
    if (s_cnt == 1 && end_seen && !csn_rose) begin
      b2b_checks++;
      chk(($time - t_end) == DIV * CLK_PERIOD, "R7 first rise after back-to-back end",
          int'($time - t_end), DIV * CLK_PERIOD);
    end
    if ((s_cnt >= 2 && s_cnt <= 8) || s_cnt >= 10)
      chk(($time - t_rise) == 2 * DIV * CLK_PERIOD, "R2 rising edge spacing",
          int'($time - t_rise), 2 * DIV * CLK_PERIOD);
    t_rise = $time;
    if (s_cnt <= 8) s_cmd = {s_cmd[6:0], spi_mosi};
    if (s_cnt == 8) begin
      chk(s_cmd == {1'b1, 4'(exp_ch[s_frame]), 3'b000}, "R3 command byte",
          int'(s_cmd), int'({1'b1, 4'(exp_ch[s_frame]), 3'b000}));
      s_val = 10'(sample_of(exp_ch[s_frame], s_frame));
    end
    if (s_cnt >= 9 && s_cnt <= 18) spi_miso = s_val[18 - s_cnt];
    else                           spi_miso = 1'b1;   // R4 junk on discarded clocks
  end

  always @(negedge spi_sclk) begin
    if (s_cnt == TOT) begin
      t_end    = $time;
      end_seen = 1'b1;
      csn_rose = 1'b0;
      s_cnt    = 0;
      s_frame  = s_frame + 1;
    end
  end

  always @(posedge spi_csn) begin
    if (!rst) begin
      csn_rose = 1'b1;
      if (s_cnt == 8) t_csr = $time;
      else chk(s_cnt == 0, "R9 chip-select rose mid-frame", s_cnt, 0);
    end
  end

  always @(negedge spi_csn) begin
    if (!rst && s_cnt == 8)
      chk(($time - t_csr) == GAPC * CLK_PERIOD, "R6 mid-frame chip-select pulse width",
          int'(($time - t_csr) / CLK_PERIOD), GAPC);
  end

  // ---------------- result monitor ----------------
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid && !prev_valid)
        chk(s_cnt == 18, "R5 result timing after clock 18", s_cnt, 18);
      if (res_valid && res_ready) begin
        chk(int'(res_data) == sample_of(exp_ch[n_rcv], n_rcv), "R4 result data",
            int'(res_data), sample_of(exp_ch[n_rcv], n_rcv));
        chk(int'(res_chan) == exp_ch[n_rcv], "R5 result channel",
            int'(res_chan), exp_ch[n_rcv]);
        n_rcv++;
      end
    end
    prev_valid = res_valid;
  end

  // ---------------- request driver ----------------
  task automatic send(input int ch);
    req_valid = 1'b1;
    req_chan  = 4'(ch);
    while (!req_ready) @(negedge clk);
    exp_ch[n_sent] = ch;
    n_sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!(n_rcv == n_sent && spi_csn)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(spi_csn && !spi_sclk && !spi_mosi, "R1 serial lines in reset",
        int'({spi_csn, spi_sclk, spi_mosi}), 4);
    chk(!res_valid, "R1 no result in reset", int'(res_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && spi_csn, "R1 ready in idle", int'({req_ready, spi_csn}), 3);

    // back-to-back sweep over every channel (R2..R7, R9)
    for (int c = 0; c < NSWEEP; c++) send(c);
    wait_idle();
    chk(b2b_checks == NSWEEP - 1, "R7 back-to-back frame count", b2b_checks, NSWEEP - 1);

    // isolated requests
    send(5);
    wait_idle();
    send(10);
    @(negedge clk);
    chk(!req_ready, "R8 not ready during frame", int'(req_ready), 0);
    wait_idle();

    // stalled result port (R8)
    res_ready = 1'b0;
    send(3);
    while (!(res_valid && spi_csn)) @(negedge clk);
    begin
      logic [9:0] held;
      int bad;
      held = res_data;
      bad = 0;
      req_valid = 1'b1;
      req_chan  = 4'd7;
      repeat (50) begin
        @(negedge clk);
        if (req_ready || !spi_csn || spi_sclk || res_data != held) bad++;
      end
      chk(bad == 0, "R8 held request starts no frame", bad, 0);
      chk(int'(res_data) == sample_of(3, n_sent - 1), "R5 stalled result kept",
          int'(res_data), sample_of(3, n_sent - 1));
    end
    res_ready = 1'b1;
    send(7);
    wait_idle();

    chk(n_rcv == n_sent, "R5 all results delivered", n_rcv, n_sent);
    chk(s_frame == n_sent, "R2 frame count", s_frame, n_sent);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_rcv, n_sent);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule